// File: doc/BRIEF.md
# Coprocessor Cycle Timer and Interrupt Source

This unit is a test-support coprocessor for a processor core. It holds sixteen 32-bit registers and answers on two coprocessor identifiers, a primary and a secondary one. Register transfers work through either identifier. Memory load/store transfers work only through the primary one. Data-operation commands are used for timed actions. Opcode 0 stalls the core for a number of cycles taken from a register. On the secondary identifier, further opcodes schedule or release an active-low fast interrupt line and an active-low normal interrupt line, or copy a free-running cycle counter into a register.

The core presents a command for one cycle. The unit answers in the next cycle with a response code: done, busy (the stall is still in progress) or cannot (the command is not supported, so the core takes its undefined-instruction path). The core and its exception entry are outside this block.

Top module: `cp_timer_irq_unit`

## Requirements
- R1: After reset both interrupt lines are high, `resp` is 0 (no response) and every register reads as zero.
- R2: A register write (`cmd_kind`=0) or a register read (`cmd_kind`=1) on either identifier uses the register at instruction bits 19:16. It responds done (`resp`=1) in the next cycle, and a read returns the value on `rd_data` in that same cycle. Both identifiers reach the same registers.
- R3: A memory load (`cmd_kind`=2) writes `cmd_wdata` to the register at bits 15:12, and a memory store (`cmd_kind`=3) returns that register on `rd_data`. On the primary identifier both respond done. On the secondary identifier both respond cannot (`resp`=3) and change nothing.
- R4: A data operation (`cmd_kind`=4) takes its opcode from bits 23:20 and its delay from the register at bits 3:0. Opcode 0 on either identifier responds busy (`resp`=2) for exactly N cycles, where N is the delay, and then responds done for one cycle. A delay of 0 gives done at once. The count stays correct when the cycle counter wraps.
- R5: On the secondary identifier, opcode 1 drives `fiq_n` low and opcode 2 drives `irq_n` low. With a delay of 0 the line is low in the cycle after the command. With a delay of N it goes low N cycles later than that. Both opcodes respond done.
- R6: The two lines count down independently. Issuing opcode 1 or 2 again while its countdown is pending restarts that countdown from the new delay.
- R7: On the secondary identifier, opcode 3 drives `fiq_n` high and opcode 4 drives `irq_n` high. Each also cancels the pending countdown of its own line.
- R8: A 32-bit cycle counter starts at `CNT_INIT` at reset, adds one every cycle and wraps. Opcode 5 on the secondary identifier writes the counter value of the command cycle into the register at bits 3:0.
- R9: Opcodes 6 to 15, any nonzero opcode on the primary identifier, and `cmd_kind` values 5 to 7 all respond cannot and change no state.
- R10: A command whose identifier matches neither `PRI_ID` nor `SEC_ID` gives no response and changes no state.
- R11: A command presented while a stall is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | A command is presented this cycle |
| cmd_cp | input | 4 | Coprocessor identifier of the command |
| cmd_kind | input | 3 | 0 reg write, 1 reg read, 2 load, 3 store, 4 data operation |
| cmd_instr | input | 32 | Instruction word holding the opcode and register fields |
| cmd_wdata | input | DATA_W | Data for register writes and loads |
| resp | output | 2 | 0 none, 1 done, 2 busy, 3 cannot |
| rd_data | output | DATA_W | Read data, valid together with done |
| fiq_n | output | 1 | Fast interrupt request, active low |
| irq_n | output | 1 | Normal interrupt request, active low |

## Verification
The bench builds the unit with identifiers 4 and 5 and with `CNT_INIT` set to 32'hFFFF_FF80, so the counter wraps about 128 cycles after reset. A 200-cycle stall is issued before that point and ends after it, which tests the wrap-safe finish comparison. Two counter snapshots, one on each side of the wrap, test that the counter rolls over to small values.

// File: rtl/cp_timer_irq_unit.sv
module cp_timer_irq_unit #(
  parameter int DATA_W = 32,
  parameter int REG_N = 16,
  parameter logic [3:0] PRI_ID = 4'd4,
  parameter logic [3:0] SEC_ID = 4'd5,
  parameter logic [DATA_W-1:0] CNT_INIT = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [3:0]        cmd_cp,
  input  logic [2:0]        cmd_kind,
  input  logic [31:0]       cmd_instr,
  input  logic [DATA_W-1:0] cmd_wdata,
  output logic [1:0]        resp,
  output logic [DATA_W-1:0] rd_data,
  output logic              fiq_n,
  output logic              irq_n
);
  localparam int IDX_W = $clog2(REG_N);
  localparam logic [2:0] K_XWR = 3'd0, K_XRD = 3'd1, K_LD = 3'd2, K_ST = 3'd3, K_OP = 3'd4;
  localparam logic [1:0] R_NONE = 2'd0, R_DONE = 2'd1, R_BUSY = 2'd2, R_CANT = 2'd3;
  localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

  logic [DATA_W-1:0] regs [REG_N];
  logic [DATA_W-1:0] cnt_q, fin_q;
  logic              stall_q;
  logic [1:0]        line_n, arm_q;
  logic [DATA_W-1:0] cd_q [2];

  logic              hit, is_pri, is_sec, is_op;
  logic [3:0]        opc;
  logic [IDX_W-1:0]  xidx, midx, didx;
  logic [DATA_W-1:0] delay, left;
  logic [1:0]        set_v, clr_v;
  logic              op_stall, op_snap, op_ok;
  logic              unused_instr;

  assign is_pri = cmd_cp == PRI_ID;
  assign is_sec = cmd_cp == SEC_ID;
  assign hit    = cmd_valid && !stall_q && (is_pri || is_sec);
  assign is_op  = hit && cmd_kind == K_OP;
  assign opc    = cmd_instr[23:20];
  assign xidx   = cmd_instr[16 +: IDX_W];
  assign midx   = cmd_instr[12 +: IDX_W];
  assign didx   = cmd_instr[0 +: IDX_W];
  assign delay  = regs[didx];
  assign left   = cnt_q - fin_q;
  assign unused_instr = ^cmd_instr;

  assign op_stall = is_op && opc == 4'd0;
  assign op_snap  = is_op && is_sec && opc == 4'd5;
  assign set_v    = {is_op && is_sec && opc == 4'd2, is_op && is_sec && opc == 4'd1};
  assign clr_v    = {is_op && is_sec && opc == 4'd4, is_op && is_sec && opc == 4'd3};
  assign op_ok    = op_stall || op_snap || (|set_v) || (|clr_v);

  assign fiq_n = line_n[0];
  assign irq_n = line_n[1];

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= CNT_INIT;
    else        cnt_q <= cnt_q + ONE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resp    <= R_NONE;
      rd_data <= '0;
      stall_q <= 1'b0;
      fin_q   <= '0;
      for (int i = 0; i < REG_N; i++) regs[i] <= '0;
    end else begin
      resp <= R_NONE;
      if (stall_q) begin
        if (!left[DATA_W-1]) begin
          resp    <= R_DONE;
          stall_q <= 1'b0;
        end else begin
          resp <= R_BUSY;
        end
      end else if (hit) begin
        case (cmd_kind)
          K_XWR: begin
            regs[xidx] <= cmd_wdata;
            resp <= R_DONE;
          end
          K_XRD: begin
            rd_data <= regs[xidx];
            resp <= R_DONE;
          end
          K_LD: begin
            if (is_pri) begin
              regs[midx] <= cmd_wdata;
              resp <= R_DONE;
            end else resp <= R_CANT;
          end
          K_ST: begin
            if (is_pri) begin
              rd_data <= regs[midx];
              resp <= R_DONE;
            end else resp <= R_CANT;
          end
          K_OP: begin
            if (!op_ok) resp <= R_CANT;
            else if (op_stall && delay != '0) begin
              resp    <= R_BUSY;
              stall_q <= 1'b1;
              fin_q   <= cnt_q + delay;
            end else begin
              resp <= R_DONE;
              if (op_snap) regs[didx] <= cnt_q;
            end
          end
          default: resp <= R_CANT;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      line_n <= 2'b11;
      arm_q  <= 2'b00;
      for (int i = 0; i < 2; i++) cd_q[i] <= '0;
    end else begin
      for (int i = 0; i < 2; i++) begin
        if (clr_v[i]) begin
          line_n[i] <= 1'b1;
          arm_q[i]  <= 1'b0;
        end else if (set_v[i]) begin
          if (delay == '0) begin
            line_n[i] <= 1'b0;
            arm_q[i]  <= 1'b0;
          end else begin
            arm_q[i] <= 1'b1;
            cd_q[i]  <= delay;
          end
        end else if (arm_q[i]) begin
          if (cd_q[i] == ONE) begin
            line_n[i] <= 1'b0;
            arm_q[i]  <= 1'b0;
          end else begin
            cd_q[i] <= cd_q[i] - ONE;
          end
        end
      end
    end
  end
endmodule

module cp_timer_irq_unit_chk #(
  parameter int DATA_W = 32,
  parameter logic [3:0] SEC_ID = 4'd5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic [3:0]        cmd_cp,
  input logic [2:0]        cmd_kind,
  input logic [31:0]       cmd_instr,
  input logic [1:0]        resp,
  input logic              fiq_n,
  input logic              irq_n,
  input logic              stall_q,
  input logic [1:0]        arm_q,
  input logic [DATA_W-1:0] cnt_q
);
  logic past_ok;
  always_ff @(posedge clk) past_ok <= rst_n;

  function automatic logic sec_op(input logic [3:0] n);
    return cmd_valid && cmd_cp == SEC_ID && cmd_kind == 3'd4 && cmd_instr[23:20] == n;
  endfunction

  AST_RESP_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && resp != 2'd0 |-> $past(cmd_valid) || $past(stall_q)); // R10
  AST_BUSY_WHILE_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
    resp == 2'd2 |-> stall_q); // R4
  AST_FIQ_FALL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && $fell(fiq_n) |-> $past(sec_op(4'd1)) || $past(arm_q[0])); // R5
  AST_IRQ_FALL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && $fell(irq_n) |-> $past(sec_op(4'd2)) || $past(arm_q[1])); // R5
  AST_FIQ_RISE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && $rose(fiq_n) |-> $past(sec_op(4'd3))); // R7
  AST_IRQ_RISE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && $rose(irq_n) |-> $past(sec_op(4'd4))); // R7
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> cnt_q == $past(cnt_q) + DATA_W'(1)); // R8
endmodule

bind cp_timer_irq_unit cp_timer_irq_unit_chk #(.DATA_W(DATA_W), .SEC_ID(SEC_ID)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_cp(cmd_cp),
  .cmd_kind(cmd_kind), .cmd_instr(cmd_instr), .resp(resp), .fiq_n(fiq_n),
  .irq_n(irq_n), .stall_q(stall_q), .arm_q(arm_q), .cnt_q(cnt_q)
);

// File: tb/cp_timer_irq_unit_bench.sv
`timescale 1ns/1ps
module cp_timer_irq_unit_bench;
  localparam logic [3:0] A = 4'd4, B = 4'd5;
  localparam logic [31:0] INIT = 32'hFFFF_FF80;
  localparam logic [1:0] R_DONE = 2'd1, R_BUSY = 2'd2, R_CANT = 2'd3;

  logic clk = 0, rst_n = 0, cmd_valid = 0;
  logic [3:0] cmd_cp = 0;
  logic [2:0] cmd_kind = 0;
  logic [31:0] cmd_instr = 0, cmd_wdata = 0;
  logic [1:0] resp;
  logic [31:0] rd_data;
  logic fiq_n, irq_n;

  cp_timer_irq_unit #(.PRI_ID(A), .SEC_ID(B), .CNT_INIT(INIT)) u_cp_timer_irq_unit (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_cp(cmd_cp),
    .cmd_kind(cmd_kind), .cmd_instr(cmd_instr), .cmd_wdata(cmd_wdata),
    .resp(resp), .rd_data(rd_data), .fiq_n(fiq_n), .irq_n(irq_n));

  always #2 clk = ~clk;

  typedef struct { logic [1:0] r; logic [31:0] d; bit chk_d; string tag; } exp_t;
  exp_t sb[$];
  exp_t cur;
  int n_chk = 0, n_fail = 0;
  logic [31:0] cyc = 0, issue_cyc = 0, snap1 = 0;

  always @(posedge clk) if (rst_n) cyc <= cyc + 1;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && resp != 2'd0) begin
      if (sb.size() == 0) check("R10 unexpected response", {30'd0, resp}, 32'd0);
      else begin
        cur = sb.pop_front();
        check({cur.tag, " resp"}, {30'd0, resp}, {30'd0, cur.r});
        if (cur.chk_d) check({cur.tag, " data"}, rd_data, cur.d);
      end
    end
  end

  function automatic logic [31:0] ins(logic [3:0] op, logic [3:0] xi, logic [3:0] mi, logic [3:0] di);
    return {8'h00, op, xi, mi, 8'h00, di};
  endfunction

  task automatic push(logic [1:0] r, logic [31:0] d, bit c, string tag);
    exp_t e;
    e.r = r; e.d = d; e.chk_d = c; e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic cmd(logic [3:0] cp, logic [2:0] k, logic [31:0] instr, logic [31:0] wd);
    @(negedge clk);
    cmd_valid = 1; cmd_cp = cp; cmd_kind = k; cmd_instr = instr; cmd_wdata = wd;
    issue_cyc = cyc;
    @(negedge clk);
    cmd_valid = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xwr(logic [3:0] cp, logic [3:0] i, logic [31:0] v);
    push(R_DONE, 0, 0, "R2 write");
    cmd(cp, 3'd0, ins(0, i, 0, 0), v);
  endtask

  task automatic xrd(logic [3:0] cp, logic [3:0] i, logic [31:0] v, string tag);
    push(R_DONE, v, 1, tag);
    cmd(cp, 3'd1, ins(0, i, 0, 0), 0);
  endtask

  task automatic dop(logic [3:0] cp, logic [3:0] op, logic [3:0] ri, logic [1:0] r, string tag);
    push(r, 0, 0, tag);
    cmd(cp, 3'd4, ins(op, 0, 0, ri), 0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    check("watchdog", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    idle(3);
    check("R1 fiq_n reset", {31'd0, fiq_n}, 1);
    check("R1 irq_n reset", {31'd0, irq_n}, 1);
    check("R1 resp reset", {30'd0, resp}, 0);
    rst_n = 1;
    for (int i = 0; i < 16; i++) xrd(A, i[3:0], 0, "R1 reg zero");

    xwr(A, 4'd1, 32'hCAFE_0001);
    xrd(B, 4'd1, 32'hCAFE_0001, "R2 shared regs");
    xwr(B, 4'd14, 32'h1234_5678);
    xrd(A, 4'd14, 32'h1234_5678, "R2 write on B");

    push(R_DONE, 0, 0, "R3 load A");
    cmd(A, 3'd2, ins(0, 0, 4'd9, 0), 32'h0BAD_F00D);
    push(R_DONE, 32'h0BAD_F00D, 1, "R3 store A");
    cmd(A, 3'd3, ins(0, 0, 4'd9, 0), 0);
    push(R_CANT, 0, 0, "R3 load B");
    cmd(B, 3'd2, ins(0, 0, 4'd9, 0), 32'hFFFF_FFFF);
    push(R_CANT, 0, 0, "R3 store B");
    cmd(B, 3'd3, ins(0, 0, 4'd9, 0), 0);
    xrd(A, 4'd9, 32'h0BAD_F00D, "R3 load on B ignored");

    dop(B, 4'd5, 4'd10, R_DONE, "R8 snap pre-wrap");
    snap1 = INIT + issue_cyc;
    xrd(A, 4'd10, snap1, "R8 snapshot value");

    xwr(A, 4'd2, 32'd200);
    for (int i = 0; i < 200; i++) push(R_BUSY, 0, 0, "R4 busy");
    push(R_DONE, 0, 0, "R4 done after wrap");
    cmd(A, 3'd4, ins(0, 0, 0, 4'd2), 0);
    cmd(A, 3'd0, ins(0, 4'd7, 0, 0), 32'hDEAD_BEEF);
    idle(201);
    xrd(A, 4'd7, 0, "R11 ignored during stall");

    dop(B, 4'd5, 4'd11, R_DONE, "R8 snap post-wrap");
    xrd(B, 4'd11, INIT + issue_cyc, "R8 wrapped value");
    check("R8 counter wrapped", {31'd0, (INIT + issue_cyc) < snap1}, 1);

    xwr(A, 4'd3, 32'd0);
    dop(B, 4'd0, 4'd3, R_DONE, "R4 zero delay on B");
    xwr(A, 4'd2, 32'd5);
    for (int i = 0; i < 5; i++) push(R_BUSY, 0, 0, "R4 busy 5");
    push(R_DONE, 0, 0, "R4 done 5");
    cmd(B, 3'd4, ins(0, 0, 0, 4'd2), 0);
    idle(6);

    dop(B, 4'd1, 4'd3, R_DONE, "R5 fiq now");
    check("R5 fiq zero delay", {31'd0, fiq_n}, 0);
    dop(B, 4'd3, 4'd0, R_DONE, "R7 fiq clear");
    check("R7 fiq released", {31'd0, fiq_n}, 1);

    xwr(A, 4'd4, 32'd4);
    dop(B, 4'd2, 4'd4, R_DONE, "R5 irq delayed");
    idle(3);
    check("R5 irq before delay", {31'd0, irq_n}, 1);
    idle(1);
    check("R5 irq after delay", {31'd0, irq_n}, 0);
    dop(B, 4'd4, 4'd0, R_DONE, "R7 irq clear");
    check("R7 irq released", {31'd0, irq_n}, 1);

    dop(B, 4'd1, 4'd4, R_DONE, "R6 arm");
    idle(1);
    dop(B, 4'd1, 4'd4, R_DONE, "R6 rearm");
    idle(3);
    check("R6 restarted countdown", {31'd0, fiq_n}, 1);
    idle(1);
    check("R6 fiq after restart", {31'd0, fiq_n}, 0);
    dop(B, 4'd3, 4'd0, R_DONE, "R7 fiq clear");

    xwr(A, 4'd6, 32'd6);
    xwr(A, 4'd5, 32'd2);
    dop(B, 4'd1, 4'd6, R_DONE, "R6 fiq arm 6");
    dop(B, 4'd2, 4'd5, R_DONE, "R6 irq arm 2");
    idle(2);
    check("R6 irq independent", {31'd0, irq_n}, 0);
    check("R6 fiq still pending", {31'd0, fiq_n}, 1);
    idle(3);
    check("R6 fiq own countdown", {31'd0, fiq_n}, 0);
    dop(B, 4'd3, 4'd0, R_DONE, "R7 fiq clear");
    dop(B, 4'd4, 4'd0, R_DONE, "R7 irq clear");

    dop(B, 4'd1, 4'd4, R_DONE, "R7 arm");
    dop(B, 4'd3, 4'd0, R_DONE, "R7 cancel");
    idle(5);
    check("R7 cancel pending", {31'd0, fiq_n}, 1);

    dop(A, 4'd1, 4'd3, R_CANT, "R9 op1 on A");
    check("R9 no fiq from A", {31'd0, fiq_n}, 1);
    dop(B, 4'd6, 4'd0, R_CANT, "R9 op6");
    dop(B, 4'd15, 4'd0, R_CANT, "R9 op15");
    dop(A, 4'd5, 4'd12, R_CANT, "R9 snap on A");
    xrd(A, 4'd12, 0, "R9 snap on A no write");
    push(R_CANT, 0, 0, "R9 kind 6");
    cmd(A, 3'd6, 0, 0);

    cmd(4'd7, 3'd0, ins(0, 4'd13, 0, 0), 32'h5555_AAAA);
    idle(2);
    xrd(A, 4'd13, 0, "R10 foreign id ignored");

    idle(3);
    check("R4 scoreboard drained", sb.size(), 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule